// File: doc/BRIEF.md
# Interrupt Mask and Condition Unit

This unit sits beside the status logic of a two-wire serial bus controller and turns the upper sixteen status flags into interrupt conditions. Every clock it takes a registered image of those flags, which is the raw condition vector. It ANDs that image with a software-owned mask to form the masked condition vector. A level interrupt is raised while any masked bit is set.

Software reaches the unit through a simple register port that performs one access per cycle. Three word addresses are decoded. The mask address can be read and written directly. The other two addresses behave differently for reads and writes. A read returns one of the two condition vectors. A write either sets mask bits (OR) or keeps only the written mask bits (AND), so bits can be changed without a read-modify-write. A synchronous full-clear input from the controller's reset logic wipes the mask and both vectors.

Top module: `irq_mask_cond`

## Requirements
- R1: After rst_n is released, the mask, both condition vectors, irq_o, rd_data_o and rd_valid_o are all zero.
- R2: A write to word address 0x08 replaces the mask with wdata_i. A read of 0x08 returns the mask.
- R3: A write to word address 0x09 sets the mask to the old mask OR wdata_i.
- R4: A write to word address 0x0A sets the mask to the old mask AND wdata_i.
- R5: A read of 0x09 returns the raw condition vector. That vector is status_i registered one cycle earlier, with bit positions kept. Bit 15 is invalid command and bit 14 is parity error, then overrun, access error, arbitration lost, NACK, data request, command complete, stop error, busy and not-busy down to bit 5. Bits 3..0 are SCL high, SCL low, SDA high and SDA low.
- R6: A read of 0x0A returns the masked condition vector, which is the raw vector AND the mask.
- R7: irq_o is high exactly when the masked vector is non-zero. It follows a change of status_i or of the mask after one clock edge, and it falls again once either clears.
- R8: A cycle with clr_all_i high clears the mask, both vectors and irq_o. This takes priority over any access made in that cycle.
- R9: A write to any other address leaves the mask unchanged. A read of any other address returns zero.
- R10: Read data is registered. rd_valid_o is high for one cycle after each read, and rd_data_o holds the register value as it stood before that edge.
- R11: Bit 4 of the raw vector is reserved and always reads zero. It can never raise irq_o, even when that bit is set in both status_i and the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_all_i | input | 1 | Synchronous full clear from controller reset |
| status_i | input | 16 | Upper status flags of the controller |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an address that means two things. The same location must return a condition vector on a read, and on a write it must change the mask without touching anything a read exposes. The stimulus table therefore interleaves OR and AND writes with reads of all three addresses under changing status patterns. After every step it reads back the mask and both vectors, so a write-path decode bug shows up as a wrong mask, and a read-path bug shows up as a wrong vector. The reserved bit is driven high in both the status and the mask, which shows it can never reach the interrupt.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int COND_W   = 16;
  localparam int RSVD_BIT = 4;
  localparam int OFF_MASK = 8;
  localparam int OFF_SET  = 9;
  localparam int OFF_CLR  = 10;

  typedef enum logic [1:0] {WK_NONE, WK_LOAD, WK_SET, WK_KEEP} wkind_e;
  typedef enum logic [1:0] {RS_NONE, RS_MASK, RS_RAW, RS_COND} rsel_e;

  localparam logic [COND_W-1:0] RSVD_MASK = ~(COND_W'(1) << RSVD_BIT);

  function automatic logic [COND_W-1:0] mask_update(
      input wkind_e k, input logic [COND_W-1:0] cur, input logic [COND_W-1:0] wd);
    case (k)
      WK_LOAD: return wd;
      WK_SET:  return cur | wd;
      WK_KEEP: return cur & wd;
      default: return cur;
    endcase
  endfunction

  function automatic logic [COND_W-1:0] raw_image(input logic [COND_W-1:0] st);
    return st & RSVD_MASK;
  endfunction
endpackage

// File: rtl/imc_decode.sv
module imc_decode
  import imc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wkind_e            wkind_o,
  output rsel_e             rsel_o,
  output logic              rd_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);

  always_comb begin
    wkind_o = WK_NONE;
    rsel_o  = RS_NONE;
    rd_o    = en_i && !wr_i;
    if (en_i && wr_i) begin
      if (addr_i == A_MASK)     wkind_o = WK_LOAD;
      else if (addr_i == A_SET) wkind_o = WK_SET;
      else if (addr_i == A_CLR) wkind_o = WK_KEEP;
    end
    if (en_i && !wr_i) begin
      if (addr_i == A_MASK)     rsel_o = RS_MASK;
      else if (addr_i == A_SET) rsel_o = RS_RAW;
      else if (addr_i == A_CLR) rsel_o = RS_COND;
    end
  end
endmodule

// File: rtl/imc_mask_reg.sv
module imc_mask_reg
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  wkind_e            wkind_i,
  input  logic [COND_W-1:0] wdata_i,
  output logic [COND_W-1:0] mask_o,
  output logic [COND_W-1:0] mask_nxt_o
);
  always_comb mask_nxt_o = clr_i ? '0 : mask_update(wkind_i, mask_o, wdata_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_o <= '0;
    else        mask_o <= mask_nxt_o;
endmodule

// File: rtl/imc_cond.sv
module imc_cond
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [COND_W-1:0] status_i,
  input  logic [COND_W-1:0] mask_nxt_i,
  output logic [COND_W-1:0] raw_o,
  output logic [COND_W-1:0] cond_o,
  output logic              irq_o
);
  logic [COND_W-1:0] raw_d, cond_d;

  always_comb begin
    raw_d  = raw_image(status_i);
    cond_d = raw_d & mask_nxt_i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw_o <= '0; cond_o <= '0; irq_o <= 1'b0;
    end else if (clr_i) begin
      raw_o <= '0; cond_o <= '0; irq_o <= 1'b0;
    end else begin
      raw_o  <= raw_d;
      cond_o <= cond_d;
      irq_o  <= |cond_d;
    end
endmodule

// File: rtl/imc_rdport.sv
module imc_rdport
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  rsel_e             rsel_i,
  input  logic [COND_W-1:0] mask_i,
  input  logic [COND_W-1:0] raw_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [COND_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [COND_W-1:0] sel_d;

  always_comb
    case (rsel_i)
      RS_MASK: sel_d = mask_i;
      RS_RAW:  sel_d = raw_i;
      RS_COND: sel_d = cond_i;
      default: sel_d = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata_o <= '0; rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= sel_d;
    end
endmodule

// File: rtl/irq_mask_cond.sv
module irq_mask_cond
  import imc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all_i,
  input  logic [15:0]       status_i,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              irq_o
);
  wkind_e            wkind;
  rsel_e             rsel;
  logic              rd_evt;
  logic [COND_W-1:0] mask_q, mask_nxt, raw_q, cond_q;

  imc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en_i(acc_en_i), .wr_i(acc_wr_i), .addr_i(acc_addr_i),
    .wkind_o(wkind), .rsel_o(rsel), .rd_o(rd_evt));

  imc_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_all_i), .wkind_i(wkind),
    .wdata_i(wdata_i), .mask_o(mask_q), .mask_nxt_o(mask_nxt));

  imc_cond u_cond (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_all_i), .status_i(status_i),
    .mask_nxt_i(mask_nxt), .raw_o(raw_q), .cond_o(cond_q), .irq_o(irq_o));

  imc_rdport u_rd (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_evt), .rsel_i(rsel),
    .mask_i(mask_q), .raw_i(raw_q), .cond_i(cond_q),
    .rdata_o(rd_data_o), .rvalid_o(rd_valid_o));
endmodule

// File: rtl/imc_chk.sv
module imc_chk
  import imc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_all_i,
  input logic              acc_en_i,
  input logic              acc_wr_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       mask_q,
  input logic [15:0]       cond_q,
  input logic              rd_valid_o,
  input logic              irq_o
);
  logic wr_load, wr_set, wr_keep;
  assign wr_load = acc_en_i && acc_wr_i && !clr_all_i && acc_addr_i == ADDR_W'(OFF_MASK);
  assign wr_set  = acc_en_i && acc_wr_i && !clr_all_i && acc_addr_i == ADDR_W'(OFF_SET);
  assign wr_keep = acc_en_i && acc_wr_i && !clr_all_i && acc_addr_i == ADDR_W'(OFF_CLR);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> mask_q == $past(wdata_i));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> mask_q == ($past(mask_q) | $past(wdata_i)));
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_keep |=> mask_q == ($past(mask_q) & $past(wdata_i)));
  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q & ~mask_q) == '0);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (cond_q != '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (mask_q == '0 && !irq_o));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all_i && !wr_load && !wr_set && !wr_keep) |=> $stable(mask_q));
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && !acc_wr_i) |=> rd_valid_o);
  p_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_q[RSVD_BIT]);
endmodule

bind irq_mask_cond imc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_all_i(clr_all_i), .acc_en_i(acc_en_i),
  .acc_wr_i(acc_wr_i), .acc_addr_i(acc_addr_i), .wdata_i(wdata_i),
  .mask_q(mask_q), .cond_q(cond_q), .rd_valid_o(rd_valid_o), .irq_o(irq_o));

// File: tb/sim_irq_mask_cond.sv
module sim_irq_mask_cond;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, en = 1'b0, wr = 1'b0;
  logic [15:0] st = '0, wd = '0;
  logic [AW-1:0] addr = '0;
  logic [15:0] rdata;
  logic rvalid, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_mask_cond #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_all_i(clr), .status_i(st), .acc_en_i(en),
    .acc_wr_i(wr), .acc_addr_i(addr), .wdata_i(wd), .rd_data_o(rdata),
    .rd_valid_o(rvalid), .irq_o(irq));

  // status, addr, wdata, expected mask, expected irq
  typedef struct packed {
    logic [15:0] s; logic [5:0] a; logic [15:0] w; logic [15:0] m; logic q;
  } vec_t;
  localparam vec_t TBL [10] = '{
    '{16'h0100, 6'h08, 16'h0100, 16'h0100, 1'b1},  // R2 direct load
    '{16'h0100, 6'h09, 16'h8000, 16'h8100, 1'b1},  // R3 OR
    '{16'h0100, 6'h0A, 16'h8000, 16'h8000, 1'b0},  // R4 AND
    '{16'h8000, 6'h03, 16'hFFFF, 16'h8000, 1'b1},  // R9 unmapped write
    '{16'h8000, 6'h0A, 16'h0000, 16'h0000, 1'b0},  // R4
    '{16'h0010, 6'h08, 16'h0010, 16'h0010, 1'b0},  // R11 reserved
    '{16'h000F, 6'h09, 16'h0003, 16'h0013, 1'b1},  // R3
    '{16'h000C, 6'h0A, 16'hFFFC, 16'h0010, 1'b0},  // R4 / R11
    '{16'hFFFF, 6'h0B, 16'h1234, 16'h0010, 1'b0},  // R9 / R11
    '{16'hFFFF, 6'h09, 16'h0001, 16'h0011, 1'b1}   // R3 / R7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    en = 1'b1; wr = w; addr = a; wd = d;
    @(negedge clk);
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    acc(1'b0, a, '0);
    chk("R10 valid", {15'd0, rvalid}, 16'd1);
    v = rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (2) @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    chk("R1 rvalid", {15'd0, rvalid}, 16'd0);
    rst_n = 1'b1;
    rd(6'h08, v); chk("R1 mask", v, 16'h0000);
    rd(6'h0A, v); chk("R1 cond", v, 16'h0000);
    @(negedge clk);
    chk("R10 one-cycle valid", {15'd0, rvalid}, 16'd0);

    foreach (TBL[i]) begin
      st = TBL[i].s;
      @(negedge clk);
      acc(1'b1, TBL[i].a, TBL[i].w);
      chk($sformatf("R7 irq step %0d", i), {15'd0, irq}, {15'd0, TBL[i].q});
      rd(6'h08, v); chk($sformatf("R2 mask step %0d", i), v, TBL[i].m);
      rd(6'h09, v); chk($sformatf("R5 raw step %0d", i), v, TBL[i].s & 16'hFFEF);
      rd(6'h0A, v); chk($sformatf("R6 cond step %0d", i), v, TBL[i].s & TBL[i].m & 16'hFFEF);
    end

    rd(6'h03, v); chk("R9 unmapped read", v, 16'h0000);

    acc(1'b1, 6'h08, 16'h0100);
    st = 16'h0100;
    @(negedge clk);
    chk("R7 irq rises on status", {15'd0, irq}, 16'd1);
    st = 16'h0000;
    @(negedge clk);
    chk("R7 irq falls on status", {15'd0, irq}, 16'd0);
    st = 16'h0100;
    @(negedge clk);
    acc(1'b1, 6'h0A, 16'h0000);
    chk("R7 irq falls on mask", {15'd0, irq}, 16'd0);

    acc(1'b1, 6'h08, 16'hFFFF);
    st = 16'hFFFF;
    @(negedge clk);
    chk("R8 pre irq", {15'd0, irq}, 16'd1);
    clr = 1'b1; en = 1'b1; wr = 1'b1; addr = 6'h09; wd = 16'hFFFF;
    @(negedge clk);
    clr = 1'b0; en = 1'b0; wr = 1'b0;
    chk("R8 irq cleared", {15'd0, irq}, 16'd0);
    rd(6'h08, v); chk("R8 mask cleared", v, 16'h0000);
    st = 16'h0000;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule